// File: doc/BRIEF.md
# Four-Channel DMA Handshake and Termination Controller

This block owns the device-facing handshake of a four-channel DMA engine. Each channel has an active-low request pin, an active-low acknowledge pin and one end/terminal pin. A single arbiter picks one requesting, armed channel at a time, using either a fixed order or a rotating order. The chosen channel's acknowledge is held low for as long as the bus access for that request is open. A bus handshake (`bus_req_o`, `bus_rdy_i`, `bus_last_i`) stands in for the memory side. One request may be split into several bus beats, and the last beat closes it.

Every channel keeps a byte count that drops by a fixed request size each time a request completes. Each channel's end/terminal pin is set on its own to work one of two ways. As an output, it pulls terminal count low alongside acknowledge during the final request of a buffer. As an input, it takes an asynchronous end-of-process falling edge that ends the buffer early. When chaining is enabled for a channel, the end of a buffer reloads the count from the last written length, and the channel keeps serving requests.

Top module: `dma_hs_ctrl`

## Requirements
- R1: After reset, all acknowledges are high, `bus_req_o` is low, every `tc_o` bit is high and every `tc_oe_o` bit is low.
- R2: A granted request on channel n drives `bus_ch_o` = n and drives only `dack_no[n]` low. The acknowledge stays low from the cycle `bus_req_o` rises until the edge where `bus_rdy_i` and `bus_last_i` are both high.
- R3: With the rotate bit at 0, the lowest-numbered requesting channel wins.
- R4: With the rotate bit at 1, the channel served last drops to lowest priority, and the search starts at the next higher channel with wrap-around. After reset, channel 0 is first in that order.
- R5: Register writes use address 0 for control and address 4+n for channel n's byte count. Writing a non-zero count arms the channel. Each completed request subtracts 4 from the count. A non-chained channel whose count reaches 0 ignores its request pin until its count is written again.
- R6: When channel n is set as a terminal-count output, `tc_oe_o[n]` is 1. `tc_o[n]` is low together with `dack_no[n]` during the request in which the remaining count is 4 or less. It stays low for every beat of that request.
- R7: When channel n is set as an input, `tc_oe_o[n]` is 0 and `tc_o[n]` is always 1.
- R8: On a channel set as an input, a falling edge on `eop_tc_i[n]` passes through a two-stage synchronizer and then ends the current buffer. If the channel is not chained, it stops serving requests until its count is written again.
- R9: On a chained channel, the end of a buffer reloads the count from the last written value and the channel stays armed. This holds whether the end comes from end-of-process or from the count reaching 0.
- R10: An edge on `eop_tc_i[n]` has no effect on a channel set as a terminal-count output.
- R11: Only one request is open at a time. `bus_ch_o` is held while it is open, and `bus_req_o` is low for at least one cycle after each request completes.
- R12: The control word is bits [3:0] for pin direction (1 = terminal-count output), bits [7:4] for chain enable per channel, and bit 8 for rotate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_ni | input | 4 | Per-channel request, active low |
| dack_no | output | 4 | Per-channel acknowledge, active low |
| eop_tc_i | input | 4 | End/terminal pad input value (asynchronous end-of-process) |
| tc_o | output | 4 | End/terminal pad output value, active-low terminal count |
| tc_oe_o | output | 4 | End/terminal pad output enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| bus_req_o | output | 1 | Request open toward the bus side |
| bus_ch_o | output | 2 | Channel of the open request |
| bus_rdy_i | input | 1 | Bus beat completes this cycle |
| bus_last_i | input | 1 | Completing beat is the last of the request |

## Verification
The hardest case to reach is the chained reload after an early end-of-process. That needs the pin set as an input, but a reload can only be seen at the ports through terminal count, which needs the pin set as an output. The stimulus therefore starts a 12-byte buffer with the pin as an input and serves one request, leaving 8 bytes. It then pulses end-of-process, switches the pin to output and counts requests: terminal count shows up on the third request, not the second. Rotating priority is reached by serving one channel alone, so the pointer has a known value, and then raising two requests at once so that the fixed order and the rotating order pick different winners.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} st_e;
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic           rotate_i,
  input  logic           upd_i,
  input  logic [CHW-1:0] upd_ch_i,
  output logic           gnt_vld_o,
  output logic [CHW-1:0] gnt_ch_o
);
  logic [CHW-1:0] ptr_q;
  int idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= CHW'(NCH - 1);
    else if (upd_i) ptr_q <= upd_ch_i;
  end

  // fixed: ascending from 0; rotating: ascending from ptr+1 with wrap
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_ch_o  = '0;
    idx       = 0;
    for (int i = 0; i < NCH; i++) begin
      idx = rotate_i ? (int'(ptr_q) + 1 + i) % NCH : i;
      if (!gnt_vld_o && req_i[idx]) begin
        gnt_vld_o = 1'b1;
        gnt_ch_o  = CHW'(idx);
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int CNT_W = 16,
  parameter int XFER  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             chain_i,
  input  logic             eop_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             armed_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(XFER);

  logic [CNT_W-1:0] len_q, cnt_q;
  logic             armed_q, pend_q;
  logic             eop_any;

  assign eop_any = eop_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (load_i) begin
      len_q   <= load_val_i;
      cnt_q   <= load_val_i;
      armed_q <= |load_val_i;
      pend_q  <= 1'b0;
    end else if (done_i) begin
      // an edge arriving while the request closes is applied next cycle
      pend_q <= pend_q | eop_i;
      if (cnt_q <= STEP) begin
        if (chain_i) begin
          cnt_q <= len_q;
        end else begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - STEP;
      end
    end else if (armed_q && eop_any && !busy_i) begin
      pend_q <= 1'b0;
      if (chain_i) begin
        cnt_q <= len_q;
      end else begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end
    end else if (armed_q && eop_i) begin
      pend_q <= 1'b1;
    end else if (!armed_q) begin
      pend_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
  assign last_o  = (cnt_q <= STEP);
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int DATA_W     = 16,
  parameter int XFER_BYTES = 4,
  localparam int CHW       = $clog2(NCH),
  localparam int ADDR_W    = CHW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    dreq_ni,
  output logic [NCH-1:0]    dack_no,
  input  logic [NCH-1:0]    eop_tc_i,
  output logic [NCH-1:0]    tc_o,
  output logic [NCH-1:0]    tc_oe_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              bus_req_o,
  output logic [CHW-1:0]    bus_ch_o,
  input  logic              bus_rdy_i,
  input  logic              bus_last_i
);
  localparam int CHAIN_LSB = NCH;
  localparam int ROT_BIT   = 2 * NCH;

  logic [NCH-1:0] dir_q, chain_q;
  logic           rot_q;
  logic           ctrl_sel, cnt_sel;
  logic [NCH-1:0] load, eop_fall, eop_evt;
  logic [NCH-1:0] armed, last, cand, sel;
  logic           gnt_vld;
  logic [CHW-1:0] gnt_ch;
  st_e            st_q;
  logic [CHW-1:0] cur_q;
  logic           tc_q;
  logic           start, done;

  assign ctrl_sel = reg_we_i && (reg_addr_i == '0);
  assign cnt_sel  = reg_we_i && reg_addr_i[ADDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      chain_q <= '0;
      rot_q   <= 1'b0;
    end else if (ctrl_sel) begin
      dir_q   <= reg_wdata_i[NCH-1:0];
      chain_q <= reg_wdata_i[CHAIN_LSB +: NCH];
      rot_q   <= reg_wdata_i[ROT_BIT];
    end
  end

  dma_sync #(.W(NCH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(eop_tc_i),
    .fall_o (eop_fall)
  );

  assign eop_evt = eop_fall & ~dir_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign load[n] = cnt_sel && (reg_addr_i[CHW-1:0] == CHW'(n));
    assign sel[n]  = (st_q == ST_XFER) && (cur_q == CHW'(n));

    dma_chan #(.CNT_W(DATA_W), .XFER(XFER_BYTES)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[n]),
      .load_val_i(reg_wdata_i),
      .chain_i   (chain_q[n]),
      .eop_i     (eop_evt[n]),
      .busy_i    (sel[n]),
      .done_i    (done && sel[n]),
      .armed_o   (armed[n]),
      .last_o    (last[n])
    );
  end

  assign cand = ~dreq_ni & armed;

  dma_arb #(.NCH(NCH)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (cand),
    .rotate_i (rot_q),
    .upd_i    (done),
    .upd_ch_i (cur_q),
    .gnt_vld_o(gnt_vld),
    .gnt_ch_o (gnt_ch)
  );

  assign start = (st_q == ST_IDLE) && gnt_vld;
  assign done  = (st_q == ST_XFER) && bus_rdy_i && bus_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      tc_q  <= 1'b0;
    end else if (start) begin
      st_q  <= ST_XFER;
      cur_q <= gnt_ch;
      tc_q  <= last[gnt_ch];
    end else if (done) begin
      st_q <= ST_IDLE;
      tc_q <= 1'b0;
    end
  end

  assign bus_req_o = (st_q == ST_XFER);
  assign bus_ch_o  = cur_q;
  assign dack_no   = ~sel;
  assign tc_o      = ~(sel & {NCH{tc_q}} & dir_q);
  assign tc_oe_o   = dir_q;
endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] dack_no,
  input logic [NCH-1:0] tc_o,
  input logic [NCH-1:0] tc_oe_o,
  input logic           bus_req_o,
  input logic [CHW-1:0] bus_ch_o,
  input logic           bus_rdy_i,
  input logic           bus_last_i
);
  logic closing;
  assign closing = bus_req_o && bus_rdy_i && bus_last_i;

  p_ack_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no));

  p_ack_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !dack_no[bus_ch_o]);

  p_ack_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> (dack_no == '1));

  p_ch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !closing) |=> (bus_req_o && $stable(bus_ch_o)));

  p_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closing |=> !bus_req_o);

  p_tc_with_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~tc_o) & dack_no) == '0);

  p_tc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tc_o != '1) && !closing) |=> $stable(tc_o));

  p_tc_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~tc_o) & ~tc_oe_o) == '0);
endmodule

bind dma_hs_ctrl dma_hs_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dack_no   (dack_no),
  .tc_o      (tc_o),
  .tc_oe_o   (tc_oe_o),
  .bus_req_o (bus_req_o),
  .bus_ch_o  (bus_ch_o),
  .bus_rdy_i (bus_rdy_i),
  .bus_last_i(bus_last_i)
);

// File: tb/dma_hs_ctrl_bench.sv
`timescale 1ns/100ps
module dma_hs_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dreq_n = 4'hf;
  logic [3:0]  dack_n;
  logic [3:0]  eop = 4'hf;
  logic [3:0]  tc_n, tc_oe;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        bus_req;
  logic [1:0]  bus_ch;
  logic        rdy = 1'b0, last_b = 1'b0;

  wire [3:0] ack_act = ~dack_n;
  wire [3:0] tc_act  = ~tc_n;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  dma_hs_ctrl u_dma_hs_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dreq_ni    (dreq_n),
    .dack_no    (dack_n),
    .eop_tc_i   (eop),
    .tc_o       (tc_n),
    .tc_oe_o    (tc_oe),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .bus_req_o  (bus_req),
    .bus_ch_o   (bus_ch),
    .bus_rdy_i  (rdy),
    .bus_last_i (last_b)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // wait for the grant of ch, run beats, check ack/tc on every beat, release request
  task automatic serve(input string req, input int ch, input int beats, input bit exp_tc);
    int n = 0;
    while (!bus_req && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk_eq({req, " R2 bus_ch"}, int'(bus_ch), ch);
    for (int b = 0; b < beats; b++) begin
      chk_eq({req, " R2 dack"}, int'(ack_act), 1 << ch);
      chk_eq({req, " R6 tc"}, int'(tc_act), exp_tc ? (1 << ch) : 0);
      rdy = 1'b1;
      last_b = (b == beats - 1);
      @(negedge clk);
    end
    rdy = 1'b0;
    last_b = 1'b0;
    dreq_n[ch] = 1'b1;
    chk_eq({req, " R11 gap bus_req"}, int'(bus_req), 0);
    chk_eq({req, " R2 dack released"}, int'(ack_act), 0);
  endtask

  task automatic expect_idle(input string req, input logic [3:0] mask, input int cyc);
    int hits = 0;
    dreq_n = dreq_n & ~mask;
    repeat (cyc) begin
      @(negedge clk);
      if (bus_req) hits++;
    end
    dreq_n = dreq_n | mask;
    chk_eq({req, " no grant"}, hits, 0);
  endtask

  task automatic eop_pulse(input int ch);
    @(negedge clk);
    eop[ch] = 1'b0;
    repeat (4) @(negedge clk);
    eop[ch] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 dack", int'(dack_n), 'hf);
    chk_eq("R1 bus_req", int'(bus_req), 0);
    chk_eq("R1 tc_o", int'(tc_n), 'hf);
    chk_eq("R1 tc_oe", int'(tc_oe), 0);
  endtask

  task automatic t_fixed_prio();
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'd8);
    wr(3'd7, 16'd8);
    @(negedge clk);
    dreq_n = 4'b0101;            // ch1 and ch3
    serve("R3 first", 1, 1, 0);
    serve("R3 second", 3, 1, 0);
  endtask

  task automatic t_rotate();
    wr(3'd0, 16'h0100);          // R12 rotate bit 8
    wr(3'd4, 16'd16);
    wr(3'd5, 16'd16);
    wr(3'd6, 16'd16);
    @(negedge clk);
    dreq_n[1] = 1'b0;
    serve("R4 alone", 1, 1, 0);
    dreq_n[0] = 1'b0;
    dreq_n[2] = 1'b0;
    serve("R4 after ch1", 2, 1, 0);
    serve("R4 wrap", 0, 1, 0);
    dreq_n[1] = 1'b0;
    dreq_n[3] = 1'b0;            // ptr=0: order 1,2,3,0 ; ch3 count 4 left
    serve("R4 order a", 1, 1, 0);
    serve("R4 order b", 3, 1, 0);
  endtask

  task automatic t_count();
    wr(3'd0, 16'h0001);          // ch0 terminal-count output
    chk_eq("R6 tc_oe", int'(tc_oe), 'h1);
    wr(3'd4, 16'd8);
    @(negedge clk);
    dreq_n[0] = 1'b0;
    serve("R5 req1", 0, 1, 0);
    dreq_n[0] = 1'b0;
    serve("R5 req2 last", 0, 1, 1);
    expect_idle("R5 count zero", 4'b0001, 12);
    chk_eq("R6 tc idle", int'(tc_n), 'hf);
  endtask

  task automatic t_split();
    wr(3'd0, 16'h0002);
    wr(3'd5, 16'd6);
    @(negedge clk);
    dreq_n[1] = 1'b0;
    serve("R6 split first", 1, 1, 0);
    dreq_n[1] = 1'b0;
    serve("R6 split last", 1, 3, 1);
  endtask

  task automatic t_input_dir();
    wr(3'd0, 16'h0000);
    chk_eq("R7 tc_oe", int'(tc_oe), 0);
    wr(3'd6, 16'd4);
    @(negedge clk);
    dreq_n[2] = 1'b0;
    serve("R7 last input", 2, 2, 0);
    chk_eq("R7 tc high", int'(tc_n), 'hf);
  endtask

  task automatic t_eop_stop();
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'd40);
    @(negedge clk);
    dreq_n[2] = 1'b0;
    serve("R8 before eop", 2, 1, 0);
    eop_pulse(2);
    expect_idle("R8 after eop", 4'b0100, 12);
  endtask

  task automatic t_eop_chain();
    wr(3'd0, 16'h0080);          // chain ch3, pin input
    wr(3'd7, 16'd12);
    @(negedge clk);
    dreq_n[3] = 1'b0;
    serve("R9 pre eop", 3, 1, 0);  // 8 left
    eop_pulse(3);
    wr(3'd0, 16'h0088);          // chain ch3, pin output
    dreq_n[3] = 1'b0;
    serve("R9 reload 1", 3, 1, 0);
    dreq_n[3] = 1'b0;
    serve("R9 reload 2", 3, 1, 0);
    dreq_n[3] = 1'b0;
    serve("R9 reload 3 last", 3, 1, 1);
    dreq_n[3] = 1'b0;
    serve("R9 zero reload", 3, 1, 0);
  endtask

  task automatic t_eop_ignored();
    wr(3'd0, 16'h0002);          // ch1 output, not chained
    wr(3'd5, 16'd8);
    eop_pulse(1);
    chk_eq("R10 tc unchanged", int'(tc_n), 'hf);
    dreq_n[1] = 1'b0;
    serve("R10 req1", 1, 1, 0);
    dreq_n[1] = 1'b0;
    serve("R10 req2 last", 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fixed_prio();
    t_rotate();
    t_count();
    t_split();
    t_input_dir();
    t_eop_stop();
    t_eop_chain();
    t_eop_ignored();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end
endmodule